// File: doc/BRIEF.md
# Resistor-Ladder Keypad Decoder

This block sits behind one converter channel wired to a resistor-ladder keypad. Each 12-bit sample (full scale 4096 codes) arrives as a stream beat. The block cuts the sample down to a 7-bit coarse index. It then waits for the same index to repeat a programmable number of times. When that happens it reports a key press, with the key number read from a 128-entry lookup table. A separate release strobe, raised by the converter's high-side comparator, reports that the last pressed key has been let go.

Software writes the nominal code of each key and the number of keys. From these the block derives the key boundaries on its own: the average spacing between neighbouring keys is computed with a small serial divider, and half of it is added to each key code. The lookup table is then refilled one entry per cycle. During a refill the input stream is held off by deasserting ready. No beat is lost; the sender keeps its beat until ready returns. The event outputs are single-cycle pulses with no back-pressure.

Top module: `adc_key_decoder`

## Requirements
- R1: After reset, both event pulses are low and a table refill runs at once with one key at code 0, a filter count of 4 and a last-pressed key of 0. `rebuilding` is high in the first cycle after reset.
- R2: `s_ready` is low whenever `rebuilding` is high or `rel_evt` is high. A beat is taken only on a cycle where `s_valid` and `s_ready` are both high.
- R3: A taken beat whose code is at or above the parameter `DOWN_CODE` has no effect: it produces no press and leaves the match state unchanged. Any other beat uses the coarse index `s_data[11:5]`.
- R4: For a taken beat below `DOWN_CODE`, the match count is incremented if the index equals the stored previous index and is set to zero otherwise. The index is then stored as the previous index. When the new count is at least the filter count, `press_valid` pulses in the next cycle, and both the count and the stored index return to zero.
- R5: `press_key` is the table entry at the coarse index of the beat that caused the press. That key also becomes the last-pressed key.
- R6: The half gap is the floor of (sum of differences between adjacent configured key codes) / (keys − 1), halved again with floor. With a single key the half gap is 0. Key k's boundary is its code plus the half gap.
- R7: One cycle after `rel_evt` is high, `release_valid` pulses with `release_key` equal to the last-pressed key. The match count and the stored previous index are cleared.
- R8: Register map: addresses 0 to MAX_KEYS−1 hold the key codes, address MAX_KEYS holds the key count, and address MAX_KEYS+1 holds the filter count (low 4 bits). A key count write of 0 is stored as 1, and a write above MAX_KEYS is stored as MAX_KEYS. A write to a key code or to the key count starts a refill and sets `rebuilding` in the next cycle. A write to the filter count does not start a refill.
- R9: The refill keeps a pointer p that starts at 0 and fills entries in order from 0 to 127. For entry i, p advances by one if p is below the key count and i·32 exceeds the boundary of key p. Entry i then takes the new p. A write during a refill restarts the refill with the new settings.
- R10: The boundary of the slot after the last key is 4095 plus the half gap. Entries beyond the last key's boundary therefore hold the key count, and a pressed key number never exceeds MAX_KEYS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat ready |
| s_data | input | CODE_W | Sample code |
| rel_evt | input | 1 | High-side comparator event (key released) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | CODE_W | Register write data |
| press_valid | output | 1 | Key press pulse |
| press_key | output | KEY_W | Pressed key number |
| release_valid | output | 1 | Key release pulse |
| release_key | output | KEY_W | Released key number |
| rebuilding | output | 1 | Table refill in progress |

## Verification
The hardest thing to reach from the ports is the table itself. Its contents can only be seen one entry at a time, through a press. A press in turn needs the right number of identical beats, and beats that fall at or above the key-down level are ignored. The bench therefore sweeps every coarse index under several ladder setups, sending filter-count-plus-one beats per index, and compares each press against a table the bench computes from the key codes. It restarts a refill by writing twice back to back, and it places an above-threshold beat in the middle of a streak to show that the streak survives.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_DIV  = 2'd1,
    B_FILL = 2'd2
  } build_st_t;
endpackage

// File: rtl/kd_gap_div.sv
module kd_gap_div #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  q;
  logic [DEN_W-1:0]  r;
  logic [STEP_W-1:0] left;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    diff;
  logic              fits;

  // one restoring step per cycle, MSB of the dividend first
  assign trial = {r, q[NUM_W-1]};
  assign diff  = trial - {1'b0, divisor};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      r    <= '0;
      left <= '0;
      done <= 1'b0;
    end else if (start) begin
      q    <= dividend;
      r    <= '0;
      left <= STEP_W'(NUM_W);
      done <= 1'b0;
    end else if (left != '0) begin
      q    <= {q[NUM_W-2:0], fits};
      r    <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      left <= left - STEP_W'(1);
      done <= (left == STEP_W'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = q;
endmodule

// File: rtl/kd_map_table.sv
module kd_map_table
  import kd_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int IDX_W    = 7,
  parameter int MAX_KEYS = 8,
  parameter int KEY_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [MAX_KEYS-1:0][CODE_W-1:0] key_codes,
  input  logic [KEY_W-1:0]               num_keys,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [KEY_W-1:0]               rd_key,
  output logic                           busy
);
  localparam int SHIFT   = CODE_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  build_st_t         st;
  logic [IDX_W-1:0]  fill_i;
  logic [KEY_W-1:0]  ptr;
  logic [KEY_W-1:0]  ptr_nx;
  logic [CODE_W-1:0] half_gap;
  logic [KEY_W-1:0]  tbl [ENTRIES];

  logic [CODE_W-1:0] first_code, last_code, ptr_code, span;
  logic [CODE_W:0]   bound, scaled;
  logic              div_start, div_done;
  logic [CODE_W-1:0] div_quo;

  // sum of adjacent differences telescopes to last minus first
  always_comb begin
    first_code = key_codes[0];
    last_code  = '0;
    ptr_code   = '1;
    for (int k = 0; k < MAX_KEYS; k++) begin
      if (KEY_W'(k + 1) == num_keys) last_code = key_codes[k];
      if (KEY_W'(k) == ptr && ptr < num_keys) ptr_code = key_codes[k];
    end
    span = (last_code > first_code) ? last_code - first_code : '0;
  end

  assign div_start = start && (num_keys > KEY_W'(1));

  kd_gap_div #(.NUM_W(CODE_W), .DEN_W(KEY_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (span),
    .divisor  (num_keys - KEY_W'(1)),
    .done     (div_done),
    .quotient (div_quo)
  );

  assign bound  = {1'b0, ptr_code} + {1'b0, half_gap};
  assign scaled = {1'b0, fill_i, {SHIFT{1'b0}}};
  assign ptr_nx = (scaled > bound && ptr < num_keys) ? ptr + KEY_W'(1) : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= B_IDLE;
      fill_i   <= '0;
      ptr      <= '0;
      half_gap <= '0;
    end else if (start) begin
      fill_i <= '0;
      ptr    <= '0;
      if (num_keys > KEY_W'(1)) begin
        st <= B_DIV;
      end else begin
        st       <= B_FILL;
        half_gap <= '0;
      end
    end else begin
      case (st)
        B_DIV: if (div_done) begin
          half_gap <= div_quo >> 1;
          st       <= B_FILL;
        end
        B_FILL: begin
          ptr    <= ptr_nx;
          fill_i <= fill_i + IDX_W'(1);
          if (fill_i == IDX_W'(ENTRIES - 1)) st <= B_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
    end else if (st == B_FILL && !start) begin
      tbl[fill_i] <= ptr_nx;
    end
  end

  assign rd_key = tbl[rd_idx];
  assign busy   = (st != B_IDLE);
endmodule

// File: rtl/kd_filter.sv
module kd_filter #(
  parameter int IDX_W  = 7,
  parameter int FILT_W = 4,
  parameter int KEY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              clear,
  input  logic [FILT_W-1:0] filt,
  output logic              press_valid,
  output logic [KEY_W-1:0]  press_key,
  output logic              release_valid,
  output logic [KEY_W-1:0]  release_key
);
  logic [FILT_W-1:0] cnt, cnt_nx;
  logic [IDX_W-1:0]  prev;
  logic [KEY_W-1:0]  last_key;

  assign cnt_nx = (idx == prev) ? cnt + FILT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= '0;
      prev          <= '0;
      last_key      <= '0;
      press_valid   <= 1'b0;
      press_key     <= '0;
      release_valid <= 1'b0;
      release_key   <= '0;
    end else begin
      press_valid   <= 1'b0;
      release_valid <= 1'b0;
      if (clear) begin
        cnt           <= '0;
        prev          <= '0;
        release_valid <= 1'b1;
        release_key   <= last_key;
      end else if (take) begin
        if (cnt_nx >= filt) begin
          press_valid <= 1'b1;
          press_key   <= key_in;
          last_key    <= key_in;
          cnt         <= '0;
          prev        <= '0;
        end else begin
          cnt  <= cnt_nx;
          prev <= idx;
        end
      end
    end
  end
endmodule

// File: rtl/adc_key_decoder.sv
module adc_key_decoder #(
  parameter int CODE_W    = 12,
  parameter int IDX_W     = 7,
  parameter int MAX_KEYS  = 8,
  parameter int FILT_W    = 4,
  parameter int FILT_DEF  = 4,
  parameter int DOWN_CODE = 3840,
  localparam int KEY_W    = $clog2(MAX_KEYS + 1),
  localparam int ADDR_W   = $clog2(MAX_KEYS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CODE_W-1:0] s_data,
  input  logic              rel_evt,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  output logic              press_valid,
  output logic [KEY_W-1:0]  press_key,
  output logic              release_valid,
  output logic [KEY_W-1:0]  release_key,
  output logic              rebuilding
);
  localparam int SHIFT = CODE_W - IDX_W;

  logic [MAX_KEYS-1:0][CODE_W-1:0] key_codes;
  logic [KEY_W-1:0]  num_keys;
  logic [KEY_W-1:0]  num_clamped;
  logic [FILT_W-1:0] filt;
  logic              start_q;
  logic              tbl_busy;
  logic [KEY_W-1:0]  tbl_key;
  logic [IDX_W-1:0]  s_idx;
  logic              take;

  always_comb begin
    if (cfg_wdata == '0)                       num_clamped = KEY_W'(1);
    else if (cfg_wdata > CODE_W'(MAX_KEYS))    num_clamped = KEY_W'(MAX_KEYS);
    else                                       num_clamped = cfg_wdata[KEY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_codes <= '0;
      num_keys  <= KEY_W'(1);
      filt      <= FILT_W'(FILT_DEF);
      start_q   <= 1'b1;
    end else begin
      start_q <= cfg_we && (cfg_addr <= ADDR_W'(MAX_KEYS));
      if (cfg_we) begin
        for (int k = 0; k < MAX_KEYS; k++)
          if (cfg_addr == ADDR_W'(k)) key_codes[k] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(MAX_KEYS))     num_keys <= num_clamped;
        if (cfg_addr == ADDR_W'(MAX_KEYS + 1)) filt     <= cfg_wdata[FILT_W-1:0];
      end
    end
  end

  assign rebuilding = start_q | tbl_busy;
  assign s_ready    = ~rebuilding & ~rel_evt;
  assign s_idx      = s_data[CODE_W-1:SHIFT];
  assign take       = s_valid && s_ready && (s_data < CODE_W'(DOWN_CODE));

  kd_map_table #(
    .CODE_W(CODE_W), .IDX_W(IDX_W), .MAX_KEYS(MAX_KEYS), .KEY_W(KEY_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_q),
    .key_codes (key_codes),
    .num_keys  (num_keys),
    .rd_idx    (s_idx),
    .rd_key    (tbl_key),
    .busy      (tbl_busy)
  );

  kd_filter #(.IDX_W(IDX_W), .FILT_W(FILT_W), .KEY_W(KEY_W)) u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .idx           (s_idx),
    .key_in        (tbl_key),
    .clear         (rel_evt),
    .filt          (filt),
    .press_valid   (press_valid),
    .press_key     (press_key),
    .release_valid (release_valid),
    .release_key   (release_key)
  );
endmodule

// File: rtl/kd_checker.sv
module kd_checker #(
  parameter int MAX_KEYS = 8,
  parameter int KEY_W    = 4,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              rel_evt,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              press_valid,
  input logic [KEY_W-1:0]  press_key,
  input logic              release_valid,
  input logic              rebuilding
);
  p_ready_low_rebuild_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rebuilding |-> !s_ready);

  p_ready_low_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |-> !s_ready);

  p_press_needs_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    press_valid |-> $past(s_valid && s_ready));

  p_release_follows_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> release_valid);

  p_release_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    release_valid |-> $past(rel_evt));

  p_refill_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr <= ADDR_W'(MAX_KEYS)) |=> rebuilding);

  p_key_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    press_valid |-> (press_key <= KEY_W'(MAX_KEYS)));
endmodule

bind adc_key_decoder kd_checker #(
  .MAX_KEYS(MAX_KEYS), .KEY_W(KEY_W), .ADDR_W(ADDR_W)
) u_kd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .rel_evt       (rel_evt),
  .cfg_we        (cfg_we),
  .cfg_addr      (cfg_addr),
  .press_valid   (press_valid),
  .press_key     (press_key),
  .release_valid (release_valid),
  .rebuilding    (rebuilding)
);

// File: tb/tb_adc_key_decoder.sv
module tb_adc_key_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int MAXK = 8;
  localparam int DOWN = 3840;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        rel_evt = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        press_valid, release_valid, rebuilding;
  logic [3:0]  press_key, release_key;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int m_kv[MAXK];
  int m_n, m_filt, m_cnt, m_prev, m_last;
  int m_tbl[128];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_key_decoder dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rel_evt(rel_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .press_valid(press_valid), .press_key(press_key), .release_valid(release_valid),
    .release_key(release_key), .rebuilding(rebuilding)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // table from the R6/R9/R10 rules
  function automatic void model_table();
    int hg, sum, p, b;
    hg = 0;
    if (m_n > 1) begin
      sum = 0;
      for (int k = 1; k < m_n; k++) sum += m_kv[k] - m_kv[k-1];
      if (sum < 0) sum = 0;
      hg = (sum / (m_n - 1)) / 2;
    end
    p = 0;
    for (int i = 0; i < 128; i++) begin
      b = (p < m_n) ? m_kv[p] + hg : 4095 + hg;
      if (i * 32 > b && p < m_n) p++;
      m_tbl[i] = p;
    end
  endfunction

  task automatic wait_idle();
    while (!s_ready) @(negedge clk);
  endtask

  task automatic cfg_write(input int addr, input int data, input bit hold);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 12'(data);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < MAXK) m_kv[addr] = data;
    else if (addr == MAXK) m_n = (data == 0) ? 1 : ((data > MAXK) ? MAXK : data);
    else m_filt = data & 15;
    model_table();
    if (addr <= MAXK) chk(rebuilding && !s_ready, "R8 refill after write", int'(rebuilding), 1);
    else chk(!rebuilding && s_ready, "R8 filter write no refill", int'(rebuilding), 0);
    if (hold) wait_idle();
  endtask

  task automatic send(input int code, input string req);
    int idx, cn;
    bit exp_p;
    int exp_k;
    @(negedge clk);
    wait_idle();
    s_valid = 1'b1; s_data = 12'(code);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    exp_p = 1'b0; exp_k = 0;
    if (code < DOWN) begin
      idx = code >> 5;
      cn = (idx == m_prev) ? m_cnt + 1 : 0;
      if (cn >= m_filt) begin
        exp_p = 1'b1; exp_k = m_tbl[idx]; m_last = exp_k; m_cnt = 0; m_prev = 0;
      end else begin
        m_cnt = cn; m_prev = idx;
      end
    end
    chk(press_valid == exp_p, req, int'(press_valid), int'(exp_p));
    if (exp_p) chk(int'(press_key) == exp_k, "R5 key from table", int'(press_key), exp_k);
  endtask

  task automatic do_release();
    @(negedge clk);
    rel_evt = 1'b1;
    #1;
    chk(!s_ready, "R2 ready low on release", int'(s_ready), 0);
    @(posedge clk);
    @(negedge clk);
    rel_evt = 1'b0;
    chk(release_valid, "R7 release pulse", int'(release_valid), 1);
    chk(int'(release_key) == m_last, "R7 release key", int'(release_key), m_last);
    m_cnt = 0; m_prev = 0;
  endtask

  // every coarse index, filter+1 beats each (R3 R4 R5 R10)
  task automatic sweep(input string tag);
    for (int idx = 0; idx < 128; idx++)
      for (int r = 0; r <= m_filt; r++)
        send(idx * 32 + (idx % 32), tag);
  endtask

  initial begin
    for (int k = 0; k < MAXK; k++) m_kv[k] = 0;
    m_n = 1; m_filt = 4; m_cnt = 0; m_prev = 0; m_last = 0;
    model_table();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rebuilding, "R1 refill after reset", int'(rebuilding), 1);
    chk(!press_valid && !release_valid, "R1 quiet after reset", int'(press_valid), 0);
    wait_idle();
    do_release();
    sweep("R4 default ladder");

    cfg_write(0, 400, 0); wait_idle();
    cfg_write(1, 1200, 1);
    cfg_write(2, 2000, 1);
    cfg_write(3, 2800, 1);
    cfg_write(MAXK, 4, 1);
    sweep("R9 four keys");

    // above-threshold beat mid-streak does not break it (R3)
    send(330, "R3 streak");
    send(330, "R3 streak");
    send(4000, "R3 ignored beat");
    send(335, "R3 streak");
    send(331, "R3 streak");
    do_release();
    send(331, "R7 counter cleared");
    do_release();

    cfg_write(MAXK + 1, 2, 1);
    for (int k = 0; k < MAXK; k++) cfg_write(k, 100 + 450 * k, 1);
    cfg_write(MAXK, 8, 1);
    sweep("R6 eight keys");

    // back-to-back writes restart the refill (R9)
    cfg_write(1, 900, 0);
    cfg_write(MAXK, 3, 1);
    sweep("R9 restart");

    // key count clamps (R8)
    cfg_write(MAXK, 0, 1);
    sweep("R8 clamp low");
    cfg_write(MAXK, 20, 1);
    chk(m_n == MAXK, "R8 clamp high model", m_n, MAXK);
    sweep("R8 clamp high");

    // filter count 0: every beat presses (R4)
    cfg_write(MAXK + 1, 0, 1);
    for (int i = 0; i < 6; i++) send(i * 600, "R4 filter zero");
    do_release();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule